// File: doc/BRIEF.md
# Prescaled Compare-Event Timer

A 16-bit up-counting timer that advances on a slow reference tick (nominally 32.768 kHz) after a power-of-two prescaler. Two compare registers watch the count. When the count steps onto a compare value, a sticky event flag is raised. Each comparator has a mode field, and a flag whose mode selects interrupt signalling drives the interrupt request output.

Software reaches the timer through a small synchronous register port with four word addresses: a setup word, the counter, and the two compare values. Writes take effect at the clock edge and reads return data in the same cycle. The enable bit and both event flags live in the setup word, and the flags are cleared by writing one. A single setup write can therefore stop the count and acknowledge both events at once.

Top module: `cmp_event_timer`

## Requirements
- R1: The setup bits 3:0 hold the prescale exponent s. While enabled, the counter advances once per 2^s reference ticks. A written value above 8 is stored and read back as 8.
- R2: The counter is 16 bits wide. It keeps counting past a compare match and wraps from 0xFFFF to 0x0000.
- R3: While the enable bit (setup bit 15) is clear, the counter holds its value whatever the reference tick does.
- R4: A write to address 1 loads the counter. A load takes priority over an advance in the same cycle.
- R5: The flag of comparator A (setup bit 13, compare value at address 2) is set when the counter advances onto that compare value. Comparator B works the same way with setup bit 14 and address 3. Loading the counter directly onto a compare value sets no flag.
- R6: A setup write with a one in a flag position clears that flag, and a zero there leaves it unchanged. If a match and a clear of the same flag happen in one cycle, the flag stays set.
- R7: Setup bits 7:6 are the mode of comparator A and bits 9:8 the mode of comparator B. The interrupt output is high exactly while some flag is set whose mode is 3. Other modes still set the flag but never raise the interrupt.
- R8: A setup write always updates the enable bit and applies the flag clears. It updates the scale and mode fields only when the counter was disabled before that write.
- R9: The prescaler restarts from zero each time the enable bit goes from clear to set.
- R10: After reset every register reads zero and the interrupt is low. Setup bits 12:10 and 5:4 always read zero.
- R11: The address map is 0 for setup, 1 for the counter, 2 for compare A and 3 for compare B. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe of the reference tick |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_wen | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
Directed runs try exponents 0, 2, 8 and a clamped 15. They tell apart a prescaler that counts ticks from one that counts clocks, and a restart on enable from a free-running divider. Further directed cases place a load, a flag clear or a setup write in the same cycle as a tick or a match. These separate the intended priorities (load over advance, set over clear, locked config while running) from their reverses. The wrap at 0xFFFF and a load onto a compare value show that a flag comes only from stepping onto a match. Thousands of random cycles then mix ticks, compare values placed just ahead of the count, and setup writes with random flag and enable bits, all checked against a bench model on every cycle.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int REG_W     = 16;
   localparam int SCALE_W   = 4;
   localparam int SCALE_LSB = 0;
   localparam int MODE_LSB  = 6;   // comparator i mode at MODE_LSB + 2*i
   localparam int FLAG_LSB  = 13;  // comparator i flag at FLAG_LSB + i
   localparam int RUN_BIT   = 15;
   localparam logic [1:0] MODE_IRQ = 2'b11;
   localparam logic [REG_W-1:0] RSVD_MASK = 16'h1C30;

   typedef enum logic [1:0] {
      A_SETUP = 2'd0,
      A_COUNT = 2'd1,
      A_CMPA  = 2'd2,
      A_CMPB  = 2'd3
   } tmr_addr_e;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
   parameter int MAX_SCALE = 8,
   parameter int SCALE_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               ref_tick,
   input  logic [SCALE_W-1:0] scale,
   output logic               step
);
   initial begin
      if (MAX_SCALE < 0 || MAX_SCALE > (1 << SCALE_W) - 1)
         $fatal(1, "tmr_prescaler: MAX_SCALE out of range");
   end

   generate
      if (MAX_SCALE == 0) begin : g_direct
         assign step = run & ref_tick;
      end else begin : g_div
         localparam int PW = MAX_SCALE;
         logic [PW-1:0] pre_q;
         logic [PW:0]   span;
         logic [PW-1:0] last;
         logic          wrap;

         assign span = (PW+1)'(1) << scale;
         assign last = PW'(span - 1'b1);
         assign wrap = (pre_q == last);
         assign step = run & ref_tick & wrap;

         always_ff @(posedge clk) begin
            if (!rst_n)          pre_q <= '0;
            else if (!run)       pre_q <= '0;
            else if (ref_tick)   pre_q <= wrap ? '0 : pre_q + 1'b1;
         end

         AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> pre_q <= last);                                  // R1
         AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run) |-> pre_q == '0);                             // R9
      end
   endgenerate
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             adv,
   output logic [CNT_W-1:0] adv_val
);
   assign adv     = step & ~load;
   assign adv_val = count + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (adv)  count <= adv_val;
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load && !step |=> $stable(count));                           // R3
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && (&count) |=> count == '0);                   // R2
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));                           // R4
endmodule

// File: rtl/tmr_compare.sv
`timescale 1ns/1ps
module tmr_compare #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             adv,
   input  logic [CNT_W-1:0] adv_val,
   input  logic             clr,
   output logic [CNT_W-1:0] cmp_val,
   output logic             flag
);
   logic hit;
   assign hit = adv & (adv_val == cmp_val);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_val <= '0;
         flag    <= 1'b0;
      end else begin
         if (wr) cmp_val <= wdata;
         flag <= hit | (flag & ~clr);
      end
   end

   AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      adv && adv_val == cmp_val |=> flag);                          // R5
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag);                                        // R6
   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !flag && !adv |=> !flag);                                      // R5
endmodule

// File: rtl/cmp_event_timer.sv
`timescale 1ns/1ps
module cmp_event_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int MAX_SCALE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             reg_wen,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq
);
   localparam int NUM_CMP = 2;

   initial begin
      if (CNT_W < 2 || CNT_W > REG_W)
         $fatal(1, "cmp_event_timer: CNT_W out of range");
      if (MAX_SCALE < 0 || MAX_SCALE > (1 << SCALE_W) - 1)
         $fatal(1, "cmp_event_timer: MAX_SCALE out of range");
   end

   logic               run_q;
   logic [SCALE_W-1:0] scale_q;
   logic [SCALE_W-1:0] scale_in;
   logic [1:0]         mode_q [NUM_CMP];
   logic [NUM_CMP-1:0] flag;
   logic [NUM_CMP-1:0] irq_src;
   logic [CNT_W-1:0]   cmp_val [NUM_CMP];
   logic               wr_setup, wr_count;
   logic               step, adv;
   logic [CNT_W-1:0]   count, adv_val;
   logic [REG_W-1:0]   setup_rd;

   assign wr_setup = reg_wen && (reg_addr == A_SETUP);
   assign wr_count = reg_wen && (reg_addr == A_COUNT);
   assign scale_in = (reg_wdata[SCALE_LSB +: SCALE_W] > SCALE_W'(MAX_SCALE))
                   ? SCALE_W'(MAX_SCALE) : reg_wdata[SCALE_LSB +: SCALE_W];

   // Setup word: enable always writable, config only while stopped
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         scale_q <= '0;
         for (int i = 0; i < NUM_CMP; i++) mode_q[i] <= 2'b00;
      end else if (wr_setup) begin
         run_q <= reg_wdata[RUN_BIT];
         if (!run_q) begin
            scale_q <= scale_in;
            for (int i = 0; i < NUM_CMP; i++)
               mode_q[i] <= reg_wdata[MODE_LSB + 2*i +: 2];
         end
      end
   end

   tmr_prescaler #(.MAX_SCALE(MAX_SCALE), .SCALE_W(SCALE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .ref_tick(ref_tick),
      .scale(scale_q), .step(step)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(wr_count),
      .load_val(reg_wdata[CNT_W-1:0]), .step(step),
      .count(count), .adv(adv), .adv_val(adv_val)
   );

   generate
      for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
         logic cmp_wr, cmp_clr;
         assign cmp_wr  = reg_wen && (reg_addr == 2'(2 + g));
         assign cmp_clr = wr_setup && reg_wdata[FLAG_LSB + g];
         tmr_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .wr(cmp_wr),
            .wdata(reg_wdata[CNT_W-1:0]), .adv(adv), .adv_val(adv_val),
            .clr(cmp_clr), .cmp_val(cmp_val[g]), .flag(flag[g])
         );
         assign irq_src[g] = flag[g] && (mode_q[g] == MODE_IRQ);
      end
   endgenerate

   assign irq = |irq_src;

   always_comb begin
      setup_rd = '0;
      setup_rd[SCALE_LSB +: SCALE_W] = scale_q;
      for (int i = 0; i < NUM_CMP; i++) begin
         setup_rd[MODE_LSB + 2*i +: 2] = mode_q[i];
         setup_rd[FLAG_LSB + i]        = flag[i];
      end
      setup_rd[RUN_BIT] = run_q;
   end

   always_comb begin
      case (reg_addr)
         A_SETUP: reg_rdata = setup_rd;
         A_COUNT: reg_rdata = REG_W'(count);
         A_CMPA:  reg_rdata = REG_W'(cmp_val[0]);
         default: reg_rdata = REG_W'(cmp_val[1]);
      endcase
   end

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|flag));                                              // R7
   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && wr_setup |=> $stable(scale_q));                       // R8
   AST_SCALE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      scale_q <= SCALE_W'(MAX_SCALE));                               // R1
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == A_SETUP |-> (reg_rdata & RSVD_MASK) == '0);        // R10
endmodule

// File: tb/tb_cmp_event_timer.sv
`timescale 1ns/1ps
module tb_cmp_event_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic        reg_wen = 1'b0;
   logic [15:0] reg_rdata;
   logic        irq;

   always #5 clk = ~clk;

   cmp_event_timer dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wen(reg_wen), .reg_rdata(reg_rdata), .irq(irq)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // bench model of the register state
   int  m_scale = 0, m_ma = 0, m_mb = 0, m_pre = 0;
   int  m_cnt = 0, m_ca = 0, m_cb = 0;
   bit  m_fa = 0, m_fb = 0, m_en = 0;

   function automatic int exp_setup();
      return (int'(m_en) << 15) | (int'(m_fb) << 14) | (int'(m_fa) << 13) |
             (m_mb << 8) | (m_ma << 6) | m_scale;
   endfunction

   function automatic int exp_irq();
      return int'((m_fa && m_ma == 3) || (m_fb && m_mb == 3));
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic expect_reg(input string tag, input bit [1:0] a, input int mask, input int exp);
      reg_addr = a;
      #1;
      check(tag, $sformatf("addr %0d", a), int'(reg_rdata) & mask, exp);
   endtask

   task automatic verify();
      expect_reg("R8", 2'd0, 16'hFFFF, exp_setup());
      expect_reg("R2", 2'd1, 16'hFFFF, m_cnt);
      expect_reg("R11", 2'd2, 16'hFFFF, m_ca);
      expect_reg("R11", 2'd3, 16'hFFFF, m_cb);
      check("R7", "irq", int'(irq), exp_irq());
   endtask

   task automatic cyc(input bit tk, input bit we, input bit [1:0] ad, input bit [15:0] wd);
      int  n_pre, n_cnt, n_scale, n_ma, n_mb, n_ca, n_cb, nxt;
      bit  stp, ld, ws, n_fa, n_fb, n_en, ha, hb;
      n_pre = m_pre; n_cnt = m_cnt; n_scale = m_scale; n_ma = m_ma; n_mb = m_mb;
      n_ca = m_ca; n_cb = m_cb; n_en = m_en; stp = 0;
      ref_tick = tk; reg_wen = we; reg_addr = ad; reg_wdata = wd;
      if (!m_en) n_pre = 0;
      else if (tk) begin
         if (m_pre == (1 << m_scale) - 1) begin n_pre = 0; stp = 1; end
         else n_pre = m_pre + 1;
      end
      ld  = we && ad == 2'd1;
      nxt = (m_cnt + 1) & 16'hFFFF;
      if (ld) n_cnt = int'(wd);
      else if (stp) n_cnt = nxt;
      ha = stp && !ld && nxt == m_ca;
      hb = stp && !ld && nxt == m_cb;
      ws = we && ad == 2'd0;
      n_fa = ha || (m_fa && !(ws && wd[13]));
      n_fb = hb || (m_fb && !(ws && wd[14]));
      if (ws) begin
         n_en = wd[15];
         if (!m_en) begin
            n_scale = (int'(wd[3:0]) > 8) ? 8 : int'(wd[3:0]);
            n_ma = int'(wd[7:6]);
            n_mb = int'(wd[9:8]);
         end
      end
      if (we && ad == 2'd2) n_ca = int'(wd);
      if (we && ad == 2'd3) n_cb = int'(wd);
      @(posedge clk);
      #1;
      m_pre = n_pre; m_cnt = n_cnt; m_scale = n_scale; m_ma = n_ma; m_mb = n_mb;
      m_ca = n_ca; m_cb = n_cb; m_en = n_en; m_fa = n_fa; m_fb = n_fb;
      reg_wen = 1'b0; ref_tick = 1'b0;
      verify();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual not finished expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      expect_reg("R10", 2'd0, 16'hFFFF, 0);
      expect_reg("R10", 2'd1, 16'hFFFF, 0);
      expect_reg("R10", 2'd2, 16'hFFFF, 0);
      check("R10", "irq after reset", int'(irq), 0);

      // R1 exponent above 8 is clamped
      cyc(0, 1, 2'd0, 16'h034F);
      expect_reg("R1", 2'd0, 16'h000F, 8);
      cyc(0, 1, 2'd3, 16'd5);
      cyc(0, 1, 2'd2, 16'd3);
      cyc(0, 1, 2'd1, 16'd0);
      cyc(0, 1, 2'd0, 16'h8340);          // run, exponent 0, mode B=3, mode A=1
      repeat (5) cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R5", 2'd1, 16'hFFFF, 5);
      expect_reg("R5", 2'd0, 16'h6000, 16'h6000);
      check("R7", "irq with mode-3 flag", int'(irq), 1);

      // R6 clear B only; R8 exponent write ignored while running
      cyc(0, 1, 2'd0, 16'hC00F);
      expect_reg("R6", 2'd0, 16'h6000, 16'h2000);
      expect_reg("R8", 2'd0, 16'h000F, 0);
      check("R7", "irq with mode-1 flag only", int'(irq), 0);

      // R6 match and clear in the same cycle: flag stays set
      cyc(0, 1, 2'd3, 16'd6);
      cyc(1, 0, 2'd0, 16'h0);
      cyc(0, 1, 2'd3, 16'd7);
      cyc(1, 1, 2'd0, 16'hC000);
      expect_reg("R6", 2'd0, 16'h4000, 16'h4000);

      // R5 load onto a compare value raises no flag
      cyc(0, 1, 2'd0, 16'hE000);
      cyc(0, 1, 2'd1, 16'd3);
      expect_reg("R5", 2'd0, 16'h2000, 0);

      // R4 load beats an advance
      cyc(1, 1, 2'd1, 16'h1234);
      expect_reg("R4", 2'd1, 16'hFFFF, 16'h1234);

      // R2 wrap
      cyc(0, 1, 2'd1, 16'hFFFF);
      cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R2", 2'd1, 16'hFFFF, 0);

      // R3 hold while disabled
      cyc(0, 1, 2'd0, 16'h0000);
      repeat (10) cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R3", 2'd1, 16'hFFFF, 0);

      // R1 exponent 2
      cyc(0, 1, 2'd0, 16'h0002);
      cyc(0, 1, 2'd0, 16'h8002);
      repeat (3) cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R1", 2'd1, 16'hFFFF, 0);
      cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R1", 2'd1, 16'hFFFF, 1);

      // R9 restart of the prescaler on enable
      repeat (2) cyc(1, 0, 2'd0, 16'h0);
      cyc(0, 1, 2'd0, 16'h0002);
      cyc(0, 1, 2'd0, 16'h8002);
      repeat (3) cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R9", 2'd1, 16'hFFFF, 1);
      cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R9", 2'd1, 16'hFFFF, 2);

      // R1 exponent 8
      cyc(0, 1, 2'd0, 16'h0008);
      cyc(0, 1, 2'd1, 16'h0000);
      cyc(0, 1, 2'd0, 16'h8008);
      repeat (255) cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R1", 2'd1, 16'hFFFF, 0);
      cyc(1, 0, 2'd0, 16'h0);
      expect_reg("R1", 2'd1, 16'hFFFF, 1);

      // R10 reserved bits
      cyc(0, 1, 2'd0, 16'h0000);
      cyc(0, 1, 2'd0, 16'h1C31);
      expect_reg("R10", 2'd0, 16'hFFFF, 16'h0001);

      // R11 address map
      cyc(0, 1, 2'd2, 16'hA5A5);
      expect_reg("R11", 2'd2, 16'hFFFF, 16'hA5A5);
      expect_reg("R11", 2'd3, 16'hFFFF, m_cb);

      // random phase, checked every cycle against the model
      for (int k = 0; k < 4000; k++) begin
         bit        tk, we;
         bit [1:0]  ad;
         bit [15:0] wd;
         tk = 1'($urandom % 2);
         we = (($urandom % 6) == 0);
         ad = 2'($urandom % 4);
         wd = 16'($urandom);
         if (ad == 2'd0) begin
            wd[3:0] = 4'($urandom % 3);
            if (($urandom % 4) != 0) wd[15] = 1'b1;
         end else if (ad == 2'd1) begin
            if (($urandom % 2) == 0) wd = 16'(m_cnt);
         end else begin
            wd = 16'(m_cnt + 1 + int'($urandom % 6));
         end
         cyc(tk, we, ad, wd);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule